// File: doc/BRIEF.md
# Dataflow Port Instruction Pump

This block controls one port that sits between a functional unit and a switch fabric. It holds a word-wide data latch and a small circular queue of instruction words. Instructions enter at the tail of the queue, which is the insertion point. The head of the queue is the execution point, and the instruction there drives the latch and the two fabric-facing handshakes. The arrival side takes incoming packets, each marked as a token or a datum. The emit side sends packets that carry a token flag, a destination address and the latch value.

Instructions can repeat. A normal instruction with a nonzero count is rewritten behind everything already queued. A count of all ones makes a standing instruction, which never runs out. Three control instructions manage the queue. A kill waits at the insertion point and removes instructions from the head. A clog parked at the head stops all execution. An unclog waits at the insertion point for that clog and then removes it.

A three-state machine governs the execution point:
- **READY**: the head instruction may take an arrival or emit.
- **EMIT**: an arrival has been taken and the output is still pending.
- **KILL**: a kill is removing head entries.

The transitions are:
- READY→EMIT when an arrival is taken and an output is still owed.
- EMIT→READY when the emit handshake completes.
- READY/EMIT→KILL when a kill is accepted.
- KILL→READY when the last victim is removed.

Top module: `port_pump`

## Requirements
- R1: After synchronous active-high reset the queue is empty and the latch is zero. out_valid and in_ready are low, and ins_ready is high for a normal instruction.
- R2: Instruction layout, LSB first: count[CNT_W-1:0], then six flags {Ti,Di,Dc,Do,To,Ig} with Ig at the lowest flag bit, then payload[DATA_W-1:0], then kind[2:0]. The kind codes are 0 normal, 1 literal, 2 kill, 3 clog and 4 unclog. Normal, literal and clog words are queued in order, and ins_ready is low for them while DEPTH entries are held.
- R3: A normal head with Ti or Di raises in_ready and waits for an arrival. With Di and Dc set, a datum arrival (in_token=0) is copied into the latch. A token arrival leaves the latch unchanged, and an arrival under Ti alone is never captured.
- R4: A normal head with Do emits a data packet (out_token=0), and one with To alone emits a token packet (out_token=1). out_data is the latch and out_addr is payload[ADDR_W-1:0]. The packet is held stable until out_ready.
- R5: On an output port (OUTPUT_PORT=1), Do and an active To together send the latch as data, addressed by the latch's top ADDR_W bits.
- R6: With Ig set, To counts only on the iteration whose count is 0.
- R7: A normal instruction with count c>0 that is not standing is rewritten at the tail with count c-1 after it completes, so it runs c+1 times, interleaved with instructions queued behind it.
- R8: A count of all ones makes a standing instruction that recirculates unchanged forever.
- R9: A literal at the head loads its payload into the latch and retires.
- R10: A kill with count c removes the next c+1 non-clog head entries, one per cycle. While it runs, the port emits nothing, takes no arrival and accepts no instruction.
- R11: A clog at the head stops execution. An unclog is accepted only while a clog is at the head, and then removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| ins_valid | input | 1 | instruction offered |
| ins_ready | output | 1 | instruction accepted this cycle |
| ins_data | input | IW | instruction word (R2 layout) |
| in_valid | input | 1 | arriving packet present |
| in_ready | output | 1 | arriving packet acknowledged |
| in_data | input | DATA_W | arriving word |
| in_token | input | 1 | arriving packet is a token |
| out_valid | output | 1 | outgoing packet present |
| out_ready | input | 1 | fabric takes the packet |
| out_data | output | DATA_W | outgoing word (latch) |
| out_addr | output | ADDR_W | outgoing destination |
| out_token | output | 1 | outgoing packet is a token |

## Verification
A wrong queue pointer or occupancy shows up within a cycle or two as a packet with the wrong destination, or as ins_ready at the wrong level. A wrong kill count or state shows up as packets that are emitted when they should have been removed, or as missing packets. A wrong latch update shows up in out_data of the next emit. The bench runs a behavioural queue model alongside the design and compares every handshake signal on every clock. It also checks the packet sequence of each scenario against hand-computed lists.

// File: rtl/pump_pkg.sv
package pump_pkg;
    typedef enum logic [2:0] {
        K_NORMAL  = 3'd0,
        K_LITERAL = 3'd1,
        K_KILL    = 3'd2,
        K_CLOG    = 3'd3,
        K_UNCLOG  = 3'd4
    } pump_kind_e;

    localparam int NFLAGS = 6;
    localparam int F_IG = 0;
    localparam int F_TO = 1;
    localparam int F_DO = 2;
    localparam int F_DC = 3;
    localparam int F_DI = 4;
    localparam int F_TI = 5;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_EMIT  = 2'd1,
        ST_KILL  = 2'd2
    } pump_state_e;
endpackage

// File: rtl/pump_fifo.sv
module pump_fifo #(
    parameter int W     = 28,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] head,
    output logic         head_valid,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [OW-1:0] occ;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            occ <= occ + OW'(push) - OW'(pop);
        end
    end

    assign head       = mem[rd_ptr];
    assign head_valid = (occ != '0);
    assign full       = (occ == OW'(DEPTH));

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        push && !pop |-> !full);
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
        pop |-> head_valid);
endmodule

// File: rtl/pump_ctrl.sv
module pump_ctrl
    import pump_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 11,
    parameter int CNT_W       = 3,
    parameter int OUTPUT_PORT = 1,
    localparam int IW = CNT_W + NFLAGS + DATA_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [IW-1:0]     ins_data,
    input  logic              head_valid,
    input  logic [IW-1:0]     head,
    input  logic              fifo_full,
    output logic              pop,
    output logic              push,
    output logic [IW-1:0]     push_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_token,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_token
);
    localparam int PAY_LO  = CNT_W + NFLAGS;
    localparam int KIND_LO = PAY_LO + DATA_W;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    pump_state_e       state, state_nx;
    logic [CNT_W-1:0]  kill_left, kill_left_nx;
    logic [DATA_W-1:0] latch;

    logic [2:0]        h_kind, i_kind;
    logic [DATA_W-1:0] h_pay;
    logic [NFLAGS-1:0] h_flg;
    logic [CNT_W-1:0]  h_cnt, cnt_next;
    logic h_normal, need_in, need_out, eff_to, standing;
    logic done, cap, lit, kill_pop, go_emit, recirc;
    logic unclog_ok, ins_fire, kill_acc, unclog_take;

    assign h_kind   = head[KIND_LO +: 3];
    assign h_pay    = head[PAY_LO +: DATA_W];
    assign h_flg    = head[CNT_W +: NFLAGS];
    assign h_cnt    = head[CNT_W-1:0];
    assign i_kind   = ins_data[KIND_LO +: 3];
    assign h_normal = (h_kind != K_LITERAL) && (h_kind != K_CLOG);
    assign standing = (h_cnt == CMAX);
    assign need_in  = h_flg[F_TI] | h_flg[F_DI];
    assign eff_to   = h_flg[F_TO] && (!h_flg[F_IG] || h_cnt == '0);
    assign need_out = h_flg[F_DO] | eff_to;
    assign cnt_next = standing ? h_cnt : h_cnt - 1'b1;

    // execution point
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        done      = 1'b0;
        cap       = 1'b0;
        lit       = 1'b0;
        kill_pop  = 1'b0;
        go_emit   = 1'b0;
        if (state == ST_KILL) begin
            kill_pop = head_valid && (h_kind != K_CLOG);
        end else if (head_valid) begin
            if (h_kind == K_LITERAL) begin
                lit  = 1'b1;
                done = 1'b1;
            end else if (h_kind != K_CLOG) begin
                if (state == ST_READY && need_in) begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        cap = h_flg[F_DI] && h_flg[F_DC] && !in_token;
                        if (need_out) go_emit = 1'b1;
                        else          done    = 1'b1;
                    end
                end else if (need_out) begin
                    out_valid = 1'b1;
                    done      = out_ready;
                end else begin
                    done = 1'b1;
                end
            end
        end
    end

    assign recirc = done && h_normal && (h_cnt != '0);

    // insertion point
    assign unclog_ok = (state != ST_KILL) && head_valid && (h_kind == K_CLOG);
    always_comb begin
        if (state == ST_KILL || recirc) begin
            ins_ready = 1'b0;
        end else begin
            unique case (i_kind)
                K_UNCLOG: ins_ready = unclog_ok;
                K_KILL:   ins_ready = 1'b1;
                default:  ins_ready = !fifo_full;
            endcase
        end
    end

    assign ins_fire    = ins_valid && ins_ready;
    assign kill_acc    = ins_fire && (i_kind == K_KILL);
    assign unclog_take = ins_fire && (i_kind == K_UNCLOG);
    assign push        = recirc || (ins_fire && !kill_acc && !unclog_take);
    assign push_data   = recirc ? {head[IW-1:CNT_W], cnt_next} : ins_data;
    assign pop         = kill_pop || done || unclog_take;

    always_comb begin
        state_nx     = state;
        kill_left_nx = kill_left;
        unique case (state)
            ST_KILL: begin
                if (kill_pop) begin
                    if (kill_left == '0) state_nx = ST_READY;
                    else kill_left_nx = kill_left - 1'b1;
                end
            end
            default: begin
                if (kill_acc) begin
                    state_nx     = ST_KILL;
                    kill_left_nx = ins_data[CNT_W-1:0];
                end else if (pop) begin
                    state_nx = ST_READY;
                end else if (go_emit) begin
                    state_nx = ST_EMIT;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_READY;
            kill_left <= '0;
            latch     <= '0;
        end else begin
            state     <= state_nx;
            kill_left <= kill_left_nx;
            if (cap)      latch <= in_data;
            else if (lit) latch <= h_pay;
        end
    end

    assign out_data  = latch;
    assign out_token = !h_flg[F_DO];
    assign out_addr  = (OUTPUT_PORT != 0 && h_flg[F_DO] && eff_to)
                       ? latch[DATA_W-1 -: ADDR_W] : h_pay[ADDR_W-1:0];

    p_hold_packet_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !kill_acc |=>
        out_valid && $stable(out_data) && $stable(out_addr));
    p_clog_stalls_r11: assert property (@(posedge clk) disable iff (rst)
        head_valid && h_kind == K_CLOG |-> !out_valid && !in_ready);
    p_kill_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        state == ST_KILL |-> !out_valid && !in_ready && !ins_ready);
    p_kill_continues_r10: assert property (@(posedge clk) disable iff (rst)
        state == ST_KILL && kill_pop && kill_left != '0 |=> state == ST_KILL);
    p_standing_r8: assert property (@(posedge clk) disable iff (rst)
        done && h_normal && standing |-> push && push_data == head);
endmodule

// File: rtl/port_pump.sv
module port_pump
    import pump_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 11,
    parameter int CNT_W       = 3,
    parameter int DEPTH       = 4,
    parameter int OUTPUT_PORT = 1,
    localparam int IW = CNT_W + NFLAGS + DATA_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [IW-1:0]     ins_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_token,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_token
);
    logic          push, pop, head_valid, full;
    logic [IW-1:0] push_data, head;

    pump_fifo #(.W(IW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .pop(pop), .push_data(push_data),
        .head(head), .head_valid(head_valid), .full(full)
    );

    pump_ctrl #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OUTPUT_PORT(OUTPUT_PORT)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_data(ins_data),
        .head_valid(head_valid), .head(head), .fifo_full(full),
        .pop(pop), .push(push), .push_data(push_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_token(in_token),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_addr(out_addr), .out_token(out_token)
    );
endmodule

// File: tb/tb_port_pump.sv
module tb_port_pump;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int IW = 28;

    logic clk = 0, rst = 1;
    logic ins_valid = 0, in_valid = 0, in_token = 0, out_ready = 1;
    logic [IW-1:0] ins_data = '0;
    logic [15:0] in_data = '0;
    logic ins_ready, in_ready, out_valid, out_token;
    logic [15:0] out_data;
    logic [10:0] out_addr;

    int tests = 0, fails = 0, cyc = 0;
    bit last_ins_fire, last_in_fire;

    // reference model state
    logic [IW-1:0] q[$];
    int st = 0;
    int kleft = 0;
    logic [15:0] lat = '0;
    logic [27:0] plog[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    port_pump dut (.*);

    function automatic logic [IW-1:0] mk(int kind, int pay, int flg, int cnt);
        return {kind[2:0], pay[15:0], flg[5:0], cnt[2:0]};
    endfunction
    function automatic logic [27:0] pk(int tok, int addr, int data);
        return {tok[0], addr[10:0], data[15:0]};
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycle();
        logic [IW-1:0] h, iw;
        bit hv, e_in, e_ov, e_ir, done, cap, lit, kpop, goemit, rec, nout, eto, fire;
        int kind, ik, cnt;
        logic [5:0] f;
        logic [15:0] pay;
        logic [10:0] e_addr;
        #1;
        hv = q.size() > 0;
        h = hv ? q[0] : '0;
        kind = int'(h[27:25]); pay = h[24:9]; f = h[8:3]; cnt = int'(h[2:0]);
        eto = f[1] && (!f[0] || cnt == 0);
        nout = f[2] || eto;
        e_in = 0; e_ov = 0; done = 0; cap = 0; lit = 0; kpop = 0; goemit = 0;
        if (st == 2) kpop = hv && kind != 3;
        else if (hv) begin
            if (kind == 1) begin lit = 1; done = 1; end
            else if (kind != 3) begin
                if (st == 0 && (f[5] || f[4])) begin
                    e_in = 1;
                    if (in_valid) begin
                        cap = f[4] && f[3] && !in_token;
                        if (nout) goemit = 1; else done = 1;
                    end
                end else if (nout) begin e_ov = 1; done = out_ready; end
                else done = 1;
            end
        end
        rec = done && kind != 1 && kind != 3 && cnt != 0;
        iw = ins_data; ik = int'(iw[27:25]);
        if (st == 2 || rec) e_ir = 0;
        else if (ik == 4) e_ir = hv && kind == 3;
        else if (ik == 2) e_ir = 1;
        else e_ir = q.size() < DEPTH;
        e_addr = (f[2] && eto) ? lat[15:5] : pay[10:0];
        chk(in_ready === e_in, "R3 in_ready", in_ready, e_in);
        chk(out_valid === e_ov, "R4 out_valid", out_valid, e_ov);
        chk(ins_ready === e_ir, "R2 ins_ready", ins_ready, e_ir);
        if (e_ov && out_valid) begin
            chk(out_data === lat, "R4 out_data", out_data, lat);
            chk(out_addr === e_addr, "R5 out_addr", out_addr, e_addr);
            chk(out_token === !f[2], "R4 out_token", out_token, !f[2]);
        end
        if (out_valid && out_ready) plog.push_back(pk(out_token, out_addr, out_data));
        last_ins_fire = ins_valid && ins_ready;
        last_in_fire = in_valid && in_ready;
        fire = ins_valid && e_ir;
        // model next state
        if (kpop || done || (fire && ik == 4)) void'(q.pop_front());
        if (rec) q.push_back({h[27:3], (cnt == 7) ? h[2:0] : 3'(cnt - 1)});
        if (fire && ik != 2 && ik != 4) q.push_back(iw);
        if (cap) lat = in_data;
        else if (lit) lat = pay;
        if (st == 2) begin
            if (kpop) begin if (kleft == 0) st = 0; else kleft--; end
        end else if (fire && ik == 2) begin st = 2; kleft = int'(iw[2:0]); end
        else if (kpop || done || (fire && ik == 4)) st = 0;
        else if (goemit) st = 1;
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic ins(logic [IW-1:0] w);
        int guard = 0;
        ins_valid = 1; ins_data = w;
        do begin cycle(); guard++; end while (!last_ins_fire && guard < 100);
        ins_valid = 0; ins_data = '0;
    endtask

    task automatic arrive(int d, bit tok);
        int guard = 0;
        in_valid = 1; in_data = d[15:0]; in_token = tok;
        do begin cycle(); guard++; end while (!last_in_fire && guard < 100);
        in_valid = 0;
    endtask

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(ins_ready === 1 && out_valid === 0 && in_ready === 0, "R1 reset idle",
            {ins_ready, out_valid, in_ready}, 3'b100);
        @(negedge clk);

        // literal then Do
        plog.delete();
        ins(mk(1, 16'hA5A5, 0, 0));
        ins(mk(0, 11'h123, 4, 0));
        run(4);
        chk(plog.size() == 1 && plog[0] == pk(0, 11'h123, 16'hA5A5), "R9 literal then emit",
            plog.size() ? plog[0] : 0, pk(0, 11'h123, 16'hA5A5));

        // token only
        plog.delete();
        ins(mk(0, 11'h055, 2, 0));
        run(3);
        chk(plog.size() == 1 && plog[0][27] == 1 && plog[0][26:16] == 11'h055, "R4 token packet",
            plog.size() ? plog[0] : 0, pk(1, 11'h055, 16'hA5A5));

        // capture, token arrival, Ti arrival
        plog.delete();
        ins(mk(0, 7, 16 + 8 + 4, 0));
        arrive(16'h1234, 0);
        run(3);
        ins(mk(0, 7, 16 + 8 + 4, 0));
        arrive(16'hFFFF, 1);
        run(3);
        ins(mk(0, 7, 32 + 4, 0));
        arrive(16'h7777, 0);
        run(3);
        chk(plog.size() == 3, "R3 three packets", plog.size(), 3);
        for (int i = 0; i < 3 && i < plog.size(); i++)
            chk(plog[i][15:0] == 16'h1234, "R3 latch after arrival", plog[i][15:0], 16'h1234);

        // send: address from latch
        plog.delete();
        ins(mk(1, 16'hABCD, 0, 0));
        ins(mk(0, 1, 4 + 2, 0));
        run(4);
        chk(plog.size() == 1 && plog[0] == pk(0, 16'hABCD >> 5, 16'hABCD), "R5 send address",
            plog.size() ? plog[0] : 0, pk(0, 16'hABCD >> 5, 16'hABCD));

        // Ig: one token over three iterations
        plog.delete();
        ins(mk(0, 9, 2 + 1, 2));
        run(8);
        chk(plog.size() == 1 && plog[0][27] == 1, "R6 token only on last", plog.size(), 1);

        // count recirculation ordering
        plog.delete();
        out_ready = 0;
        ins(mk(0, 11'h0A, 4, 1));
        ins(mk(0, 11'h0B, 4, 0));
        out_ready = 1;
        run(6);
        chk(plog.size() == 3, "R7 three emits", plog.size(), 3);
        if (plog.size() == 3)
            chk(plog[0][26:16] == 11'h0A && plog[1][26:16] == 11'h0B && plog[2][26:16] == 11'h0A,
                "R7 recirculated order", {plog[0][26:16], plog[1][26:16], plog[2][26:16]}, 33'h0A_0B_0A);

        // standing, then kill it
        plog.delete();
        ins(mk(0, 3, 4, 7));
        run(6);
        chk(plog.size() >= 5, "R8 standing repeats", plog.size(), 5);
        out_ready = 0;
        ins(mk(2, 0, 0, 0));
        out_ready = 1;
        n0 = plog.size();
        run(8);
        chk(plog.size() == n0, "R10 standing killed", plog.size(), n0);

        // full stall, kill 3 of 4
        plog.delete();
        out_ready = 0;
        for (int i = 1; i <= 4; i++) ins(mk(0, i, 4, 0));
        ins_valid = 1; ins_data = mk(0, 9, 4, 0);
        run(2);
        chk(ins_ready === 0, "R2 full stalls insertion", ins_ready, 0);
        ins_valid = 0;
        ins(mk(2, 0, 0, 2));
        out_ready = 1;
        run(8);
        chk(plog.size() == 1 && plog[0][26:16] == 4, "R10 kill count 2 removes three",
            plog.size() ? plog[0][26:16] : 0, 4);

        // clog and unclog
        plog.delete();
        ins(mk(3, 0, 0, 0));
        ins(mk(0, 5, 4, 0));
        run(6);
        chk(plog.size() == 0, "R11 clog blocks", plog.size(), 0);
        ins(mk(4, 0, 0, 0));
        run(4);
        chk(plog.size() == 1 && plog[0][26:16] == 5, "R11 unclog releases", plog.size(), 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule